// File: doc/BRIEF.md
# Reset-Release Configuration Loader

The block fills an eight-bit control register from a fixed program-storage location each time the external reset pin returns high. When the pin rises it issues a single read of address 0x00FFF3. The test-pin level at the moment of the rise decides whether the read goes to the internal boot ROM or over the external bus pins. The read is held until the memory answers, and the returned byte is then written into the register. Until that happens the register holds all ones, a busy flag is raised and the CPU enable is held off.

The register fields drive the chip's start-up configuration:
- internal RAM enable and internal CPU enable;
- selection of the program storage (internal flash, boot ROM or external storage);
- the mode of the multifunction pins.

The block also times the open-drain pull that drives the reset pin low after an internal reset request. The pull is short or long, depending on the stored byte, the test pin, and whether this is the first request since power-on.

Top module: `cfg_boot_loader`

## Requirements
- R1: After the synchronous power-on reset `rst`, `cfg_q` reads 0xFF, `cfg_busy` is 1, `mem_rd_en` is 0 and `rst_pin_pull_low` is 0.
- R2: The cycle after `rst_pin_level` is seen rising, `mem_rd_en` goes to 1 with `mem_addr` = 0x00FFF3. It stays at 1 until a cycle with `mem_rvalid` = 1. The byte on `mem_rdata` in that cycle appears on `cfg_q` one cycle later, and `cfg_busy` falls at the same time.
- R3: `mem_src_ext` equals the `test_pin` level sampled together with the rise (0 = boot ROM, 1 = external bus). It holds that value while the fetch is in progress, even if `test_pin` changes.
- R4: Whenever `rst_pin_level` is sampled low, the register returns to 0xFF, `cfg_busy` returns to 1 and any pending read is dropped. A low pin in the same cycle as `mem_rvalid` wins over the capture.
- R5: `ram_en` is register bit 1. `cpu_en` is register bit 0 and is forced to 0 while `cfg_busy` is 1.
- R6: Bit 4 = 1 selects internal flash. Bit 4 = 0 with bit 2 = 1 selects the boot ROM. Bits 4 and 2 both 0 select external storage. Exactly one of `sel_flash`, `sel_bootrom`, `sel_external` is 1.
- R7: While `cfg_busy` is 1, `bus_mode` equals `mem_src_ext`. Afterwards, if bit 6 is 1, `bus_mode` follows the live `test_pin`; otherwise `bus_mode` equals `sel_external`.
- R8: A one-cycle `int_reset_req` pulls the pin low from the next cycle onward. With `test_pin` = 0 at the request, the pull lasts 4096 cycles.
- R9: With `test_pin` = 1, the first request after power-on reset gives a 16-cycle pull, whatever the register holds.
- R10: With `test_pin` = 1, later requests give 16 cycles if bit 7 of the register value held in the request cycle is 1, and 4096 cycles if it is 0. A request in the capture cycle uses the pre-capture value 0xFF.
- R11: A request that arrives while a pull is in progress restarts the pull with the full length chosen for the new request.
- R12: A byte of 0xFF fetched with `test_pin` = 0 enables flash, RAM and CPU with `bus_mode` = 0. A byte of 0xAB fetched with `test_pin` = 1 selects external storage with RAM and CPU enabled and `bus_mode` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_pin_level | input | 1 | Synchronised level of the external reset pin |
| test_pin | input | 1 | Test pin level |
| int_reset_req | input | 1 | One-cycle internal reset request |
| rst_pin_pull_low | output | 1 | Open-drain enable; 1 pulls the reset pin low |
| mem_rd_en | output | 1 | Configuration read request |
| mem_addr | output | 24 | Read address (0x00FFF3 while reading, else 0) |
| mem_src_ext | output | 1 | Read source: 0 boot ROM, 1 external bus |
| mem_rdata | input | 8 | Returned byte |
| mem_rvalid | input | 1 | Returned byte valid |
| cfg_q | output | 8 | Control register contents |
| cfg_busy | output | 1 | Fetch not yet completed |
| ram_en | output | 1 | Internal RAM enable |
| cpu_en | output | 1 | Internal CPU enable |
| sel_flash | output | 1 | Program storage is internal flash |
| sel_bootrom | output | 1 | Program storage is boot ROM |
| sel_external | output | 1 | Program storage is external |
| bus_mode | output | 1 | Multifunction pins in bus mode |

## Verification
Two functions can collide in one cycle: the capture of the fetched byte, and a decision that reads the register in that same cycle. The decision is either the length of a newly requested reset pull or the abort caused by a falling pin. The bench raises `int_reset_req` in exactly the cycle in which `mem_rvalid` returns a byte with bit 7 clear, and it expects a 16-cycle pull because the old all-ones value must govern. It also drops `rst_pin_level` together with `mem_rvalid` and expects the register to stay at 0xFF with the fetch abandoned. A behavioural model compares every output on every clock, and directed pulse-length measurements back up the model.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

    localparam int CFG_W = 8;

    // Control register layout; bit positions are decoded by neighbours.
    typedef struct packed {
        logic short_rst;   // 7: 1 = short reset pull
        logic pin_toggle;  // 6: test pin steers multifunction pins when done
        logic spare_hi;    // 5: stored only
        logic flash_sel;   // 4: internal flash is program storage
        logic spare_lo;    // 3: stored only
        logic irom_sel;    // 2: boot ROM when flash_sel is 0
        logic ram_on;      // 1: internal RAM enable
        logic cpu_on;      // 0: internal CPU enable
    } cfg_byte_t;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_FETCH = 2'd1,
        FS_DONE  = 2'd2
    } fetch_state_t;

    typedef enum logic [1:0] {
        STORE_FLASH    = 2'd0,
        STORE_BOOTROM  = 2'd1,
        STORE_EXTERNAL = 2'd2
    } store_sel_t;

    localparam cfg_byte_t CFG_DEFAULT = '1;

    function automatic store_sel_t decode_store(logic flash_bit, logic irom_bit);
        if (flash_bit)     return STORE_FLASH;
        else if (irom_bit) return STORE_BOOTROM;
        else               return STORE_EXTERNAL;
    endfunction

    // Short pull only when the test pin is high and either this is the
    // first request since power-on or the register asks for it.
    function automatic logic pick_short(logic test_lvl, logic first_req, logic short_bit);
        return test_lvl & (first_req | short_bit);
    endfunction

endpackage

// File: rtl/cbl_fetch_seq.sv
module cbl_fetch_seq
    import cbl_pkg::*;
#(
    parameter int              ADDR_W   = 24,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 24'h00FFF3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_in,
    input  logic              test_pin,
    input  logic [CFG_W-1:0]  mem_rdata,
    input  logic              mem_rvalid,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_src_ext,
    output cfg_byte_t         cfg_q,
    output logic              busy
);

    fetch_state_t state_q;
    logic         pin_q;
    logic         src_q;
    cfg_byte_t    reg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            pin_q   <= 1'b0;
            src_q   <= 1'b0;
            reg_q   <= CFG_DEFAULT;
        end else begin
            pin_q <= pin_in;
            if (!pin_in) begin
                state_q <= FS_IDLE;
                reg_q   <= CFG_DEFAULT;
            end else begin
                unique case (state_q)
                    FS_IDLE: begin
                        if (!pin_q) begin
                            state_q <= FS_FETCH;
                            src_q   <= test_pin;
                        end
                    end
                    FS_FETCH: begin
                        if (mem_rvalid) begin
                            reg_q   <= cfg_byte_t'(mem_rdata);
                            state_q <= FS_DONE;
                        end
                    end
                    default: state_q <= state_q;
                endcase
            end
        end
    end

    assign mem_rd_en   = (state_q == FS_FETCH);
    assign mem_addr    = mem_rd_en ? CFG_ADDR : '0;
    assign mem_src_ext = src_q;
    assign cfg_q       = reg_q;
    assign busy        = (state_q != FS_DONE);

    AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && !mem_rvalid && pin_in) |=> mem_rd_en); // R2

    AST_DEFAULT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cfg_q == CFG_DEFAULT)); // R4

    AST_SRC_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && $past(mem_rd_en)) |-> $stable(mem_src_ext)); // R3

endmodule

// File: rtl/cbl_mode_decode.sv
module cbl_mode_decode
    import cbl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic src_ext,
    input  logic test_pin,
    input  logic flash_bit,
    input  logic irom_bit,
    input  logic toggle_bit,
    input  logic ram_bit,
    input  logic cpu_bit,
    output logic ram_en,
    output logic cpu_en,
    output logic sel_flash,
    output logic sel_bootrom,
    output logic sel_external,
    output logic bus_mode
);

    store_sel_t store;

    always_comb begin
        store        = decode_store(flash_bit, irom_bit);
        sel_flash    = (store == STORE_FLASH);
        sel_bootrom  = (store == STORE_BOOTROM);
        sel_external = (store == STORE_EXTERNAL);
        ram_en       = ram_bit;
        cpu_en       = cpu_bit & ~busy;
        if (busy)            bus_mode = src_ext;
        else if (toggle_bit) bus_mode = test_pin;
        else                 bus_mode = (store == STORE_EXTERNAL);
    end

    AST_CPU_GATED: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cpu_en); // R5

    AST_ONE_STORE: assert property (@(posedge clk) disable iff (rst)
        $countones({sel_flash, sel_bootrom, sel_external}) == 1); // R6

endmodule

// File: rtl/cbl_rst_pulse.sv
module cbl_rst_pulse
    import cbl_pkg::*;
#(
    parameter int SHORT_LEN = 16,
    parameter int LONG_LEN  = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic test_pin,
    input  logic short_bit,
    output logic pull_low
);

    localparam int CNT_W = $clog2(LONG_LEN + 1);
    localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_LEN);
    localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_LEN);

    logic [CNT_W-1:0] cnt_q;
    logic             first_q;
    logic [CNT_W-1:0] load_len;

    always_comb begin
        load_len = pick_short(test_pin, first_q, short_bit) ? SHORT_V : LONG_V;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            first_q <= 1'b1;
        end else if (req) begin
            cnt_q   <= load_len;
            first_q <= 1'b0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pull_low = (cnt_q != '0);

    AST_PULL_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req |=> pull_low); // R11

    AST_NO_PULL_AT_BOOT: assert property (@(posedge clk) disable iff (rst)
        first_q |-> !pull_low); // R1

endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
    import cbl_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int SHORT_LEN = 16,
    parameter int LONG_LEN  = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_pin_level,
    input  logic              test_pin,
    input  logic              int_reset_req,
    output logic              rst_pin_pull_low,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_src_ext,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_rvalid,
    output logic [7:0]        cfg_q,
    output logic              cfg_busy,
    output logic              ram_en,
    output logic              cpu_en,
    output logic              sel_flash,
    output logic              sel_bootrom,
    output logic              sel_external,
    output logic              bus_mode
);

    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(24'h00FFF3);

    cfg_byte_t cfg_s;
    logic      busy_s;

    cbl_fetch_seq #(
        .ADDR_W  (ADDR_W),
        .CFG_ADDR(CFG_ADDR)
    ) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .pin_in     (rst_pin_level),
        .test_pin   (test_pin),
        .mem_rdata  (mem_rdata),
        .mem_rvalid (mem_rvalid),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .mem_src_ext(mem_src_ext),
        .cfg_q      (cfg_s),
        .busy       (busy_s)
    );

    cbl_mode_decode u_decode (
        .clk         (clk),
        .rst         (rst),
        .busy        (busy_s),
        .src_ext     (mem_src_ext),
        .test_pin    (test_pin),
        .flash_bit   (cfg_s.flash_sel),
        .irom_bit    (cfg_s.irom_sel),
        .toggle_bit  (cfg_s.pin_toggle),
        .ram_bit     (cfg_s.ram_on),
        .cpu_bit     (cfg_s.cpu_on),
        .ram_en      (ram_en),
        .cpu_en      (cpu_en),
        .sel_flash   (sel_flash),
        .sel_bootrom (sel_bootrom),
        .sel_external(sel_external),
        .bus_mode    (bus_mode)
    );

    cbl_rst_pulse #(
        .SHORT_LEN(SHORT_LEN),
        .LONG_LEN (LONG_LEN)
    ) u_pulse (
        .clk      (clk),
        .rst      (rst),
        .req      (int_reset_req),
        .test_pin (test_pin),
        .short_bit(cfg_s.short_rst),
        .pull_low (rst_pin_pull_low)
    );

    assign cfg_q    = cfg_s;
    assign cfg_busy = busy_s;

endmodule

// File: tb/cfg_boot_loader_tb_top.sv
module cfg_boot_loader_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin = 1'b0;
    logic        tpin = 1'b0;
    logic        req = 1'b0;
    logic        pull;
    logic        rd_en;
    logic [23:0] addr;
    logic        src;
    logic [7:0]  rdata = 8'h00;
    logic        rvalid = 1'b0;
    logic [7:0]  cfg;
    logic        busy, ram, cpu, sf, sb, se, bmode;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    // behavioural reference state
    int         m_state = 0;   // 0 waiting, 1 reading, 2 loaded
    bit         m_pinq  = 0;
    bit         m_src   = 0;
    bit [7:0]   m_cfg   = 8'hFF;
    int         m_cnt   = 0;
    bit         m_first = 1;

    always #2 clk = ~clk;   // 250 MHz

    cfg_boot_loader dut_i (
        .clk(clk), .rst(rst), .rst_pin_level(pin), .test_pin(tpin),
        .int_reset_req(req), .rst_pin_pull_low(pull),
        .mem_rd_en(rd_en), .mem_addr(addr), .mem_src_ext(src),
        .mem_rdata(rdata), .mem_rvalid(rvalid),
        .cfg_q(cfg), .cfg_busy(busy), .ram_en(ram), .cpu_en(cpu),
        .sel_flash(sf), .sel_bootrom(sb), .sel_external(se), .bus_mode(bmode)
    );

    task automatic check(string tag, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // model update on each rising edge
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_state = 0; m_pinq = 0; m_src = 0; m_cfg = 8'hFF; m_cnt = 0; m_first = 1;
        end else begin
            if (req) begin
                m_cnt   = (tpin && (m_first || m_cfg[7])) ? 16 : 4096;
                m_first = 0;
            end else if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
            end
            if (!pin) begin
                m_state = 0; m_cfg = 8'hFF;
            end else if (m_state == 0 && !m_pinq) begin
                m_state = 1; m_src = tpin;
            end else if (m_state == 1 && rvalid) begin
                m_cfg = rdata; m_state = 2;
            end
            m_pinq = pin;
        end
    end

    // full comparison every cycle, after inputs have settled
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            bit b, ext, bm;
            b   = (m_state != 2);
            ext = !m_cfg[4] && !m_cfg[2];
            bm  = b ? m_src : (m_cfg[6] ? tpin : ext);
            check("R2 cfg_q",     cfg, m_cfg);
            check("R2 busy",      busy, b);
            check("R2 rd_en",     rd_en, m_state == 1);
            check("R2 addr",      addr, (m_state == 1) ? 24'h00FFF3 : 24'h0);
            check("R3 src",       src, m_src);
            check("R5 ram/cpu",   {ram, cpu}, {m_cfg[1], m_cfg[0] && !b});
            check("R6 select",    {sf, sb, se}, {m_cfg[4], !m_cfg[4] && m_cfg[2], ext});
            check("R7 bus_mode",  bmode, bm);
            check("R8 pull",      pull, m_cnt != 0);
        end
    end

    task automatic boot(input bit [7:0] b, input bit t, input int dly);
        @(negedge clk); pin = 1'b0; tpin = t;
        repeat (2) @(negedge clk);
        pin = 1'b1;
        repeat (dly) @(negedge clk);
        rvalid = 1'b1; rdata = b;
        @(negedge clk); rvalid = 1'b0;
        @(negedge clk);
    endtask

    // request one pull and measure its length in cycles
    task automatic pulse(input bit t, output int n);
        @(negedge clk); req = 1'b1; tpin = t;
        @(negedge clk); req = 1'b0;
        n = 0;
        while (pull) begin n++; @(negedge clk); end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 cfg after reset", cfg, 8'hFF);
        check("R1 busy after reset", busy, 1);
        check("R1 no read/pull", {rd_en, pull}, 2'b00);

        // R9 first request with test high is short
        pulse(1'b1, n);
        check("R9 first pull length", n, 16);

        // R12 external boot, R2 held read
        @(negedge clk); pin = 1'b0; tpin = 1'b1;
        repeat (2) @(negedge clk);
        pin = 1'b1;
        repeat (5) @(negedge clk);
        check("R2 read held without valid", rd_en, 1);
        check("R3 source external", src, 1);
        rvalid = 1'b1; rdata = 8'hAB;
        @(negedge clk); rvalid = 1'b0;
        @(negedge clk);
        check("R12 AB captured", cfg, 8'hAB);
        check("R12 AB external bus", {se, bmode, ram, cpu}, 4'b1111);

        // R10 later request follows bit 7
        pulse(1'b1, n);
        check("R10 short bit set", n, 16);
        boot(8'h2B, 1'b1, 2);
        pulse(1'b1, n);
        check("R10 short bit clear", n, 4096);

        // R12 stand-alone, R8 test low is always long
        boot(8'hFF, 1'b0, 1);
        check("R12 FF flash", {sf, ram, cpu, bmode}, 4'b1110);
        check("R3 source boot ROM", src, 0);
        pulse(1'b0, n);
        check("R8 test low long", n, 4096);

        // R11 restart during a pull
        @(negedge clk); req = 1'b1; tpin = 1'b0;
        @(negedge clk); req = 1'b0;
        n = 0;
        while (pull) begin
            n++;
            if (n == 50) begin req = 1'b1; tpin = 1'b1; end
            else req = 1'b0;
            @(negedge clk);
        end
        req = 1'b0;
        check("R11 restarted length", n, 66);

        // R4 abort during fetch
        @(negedge clk); pin = 1'b0; tpin = 1'b0;
        repeat (2) @(negedge clk);
        pin = 1'b1;
        repeat (2) @(negedge clk);
        pin = 1'b0;
        @(negedge clk);
        check("R4 abort clears read", {rd_en, busy, cfg}, {2'b01, 8'hFF});
        // R4 pin low in the capture cycle wins
        pin = 1'b1;
        repeat (2) @(negedge clk);
        rvalid = 1'b1; rdata = 8'h00; pin = 1'b0;
        @(negedge clk); rvalid = 1'b0;
        @(negedge clk);
        check("R4 low beats capture", {busy, cfg}, {1'b1, 8'hFF});

        // R10 request in capture cycle uses old all-ones value
        pin = 1'b1; tpin = 1'b1;
        repeat (2) @(negedge clk);
        rvalid = 1'b1; rdata = 8'h03; req = 1'b1;
        @(negedge clk); rvalid = 1'b0; req = 1'b0;
        n = 0;
        while (pull) begin n++; @(negedge clk); end
        check("R10 collision uses pre-capture", n, 16);
        check("R10 byte still captured", cfg, 8'h03);

        // R6 boot ROM, R5 disables
        boot(8'h07, 1'b0, 1);
        check("R6 boot ROM select", {sf, sb, se}, 3'b010);
        boot(8'h00, 1'b0, 1);
        check("R6 external select", {sf, sb, se}, 3'b001);
        check("R5 RAM/CPU off", {ram, cpu}, 2'b00);

        // R7 toggle bit lets test pin steer pins
        boot(8'h53, 1'b0, 1);
        tpin = 1'b1; @(negedge clk); #1;
        check("R7 toggle follows test high", bmode, 1);
        tpin = 1'b0; @(negedge clk); #1;
        check("R7 toggle follows test low", bmode, 0);

        // R3 source held although test pin changes during read
        @(negedge clk); pin = 1'b0; tpin = 1'b1;
        repeat (2) @(negedge clk);
        pin = 1'b1;
        @(negedge clk); tpin = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 source held", {src, bmode}, 2'b11);
        rvalid = 1'b1; rdata = 8'hFF;
        @(negedge clk); rvalid = 1'b0;
        repeat (3) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule